// File: doc/BRIEF.md
# Misaligned Access Split Unit

This unit sits between a load/store issue port and a memory interface whose data path is 64 bits (one 8-byte beat) wide. A request carries a byte address, a size code, a read/write direction, write data and a flag that demands natural alignment. When the access fits inside one beat, the unit sends one memory transaction. When the access spills over a beat boundary, the unit sends it as a series of beat transactions in ascending address order, one at a time. Each transaction carries a byte-lane mask and a piece index. Read pieces are stitched back into a single little-endian result.

The unit also reports whether the bytes of the access fall in two cache lines or in two 4096-byte pages, so that the translation and cache logic beyond it can charge the extra lookup. If alignment is demanded and the address is not a multiple of the access size, the unit answers with a fault and touches no memory. If the memory reports an error on any piece, the unit abandons the request and issues none of the remaining pieces. While a request is in progress the unit is busy and takes no new request.

Top module: `mis_split_unit`

## Requirements
- R1: During and right after reset, `busy`, `mem_valid` and `resp_valid` are all low.
- R2: The size code gives 1, 2, 4, 8 or 16 bytes for codes 0, 1, 2, 3 and 4. An access whose bytes fit in one 8-byte beat produces exactly one memory transaction. That transaction has piece index 0 and the beat-aligned address (address with bits [2:0] cleared). Its lane mask has as many bits set as the access has bytes, beginning at lane address[2:0].
- R3: An access that crosses a beat boundary produces one transaction per touched beat. The pieces go out with indices 0, 1, 2 and addresses rising by 8 each time. The first mask runs from lane address[2:0] up to lane 7. Every later mask starts at lane 0, and the last mask ends on the final byte.
- R4: For writes, request data byte i appears on the lane of memory byte address+i, inside the piece that holds that byte.
- R5: For reads, byte i of the result comes from memory byte address+i, and result bytes at and above the access size are zero. The response is valid for exactly one cycle, in the cycle after the last piece's return. The result is zero for writes and for faults.
- R6: `busy` is high from the cycle after a request is accepted through its response cycle. A request presented while `busy` is high is ignored.
- R7: If the alignment flag is set and the address is not a multiple of the access size, the unit issues no memory transaction. Instead it answers with `resp_fault` high in the cycle after acceptance.
- R8: A naturally aligned request with the alignment flag set completes normally. A misaligned request with the flag clear is split normally.
- R9: `resp_line_x` is high when the first and last bytes of the access lie in different lines of `LINE_BYTES` bytes.
- R10: `resp_page_x` is high when the first and last bytes lie in different 4096-byte pages. A 16-byte access at page offset 4088 is issued as two pieces, one in each page.
- R11: A memory error on any piece ends the request with `resp_fault` high, and no later piece is issued.
- R12: A 16-byte access on a 16-byte boundary never reports a line crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present (taken only when not busy) |
| req_addr | input | AW | Byte address |
| req_size | input | 3 | Size code: 0=1B, 1=2B, 2=4B, 3=8B, 4=16B |
| req_write | input | 1 | 1 = store, 0 = load |
| req_align | input | 1 | Natural alignment demanded |
| req_wdata | input | 128 | Store data, byte 0 in bits [7:0] |
| busy | output | 1 | Request in progress |
| mem_valid | output | 1 | One-cycle memory transaction strobe |
| mem_addr | output | AW | Beat-aligned address |
| mem_write | output | 1 | Transaction direction |
| mem_mask | output | 8 | Byte-lane enables |
| mem_wdata | output | 64 | Beat write data |
| mem_tag | output | 2 | Piece index within the request |
| mem_rvalid | input | 1 | Return for the outstanding transaction |
| mem_rdata | input | 64 | Returned beat data |
| mem_rerr | input | 1 | Memory error on this return |
| resp_valid | output | 1 | Response strobe |
| resp_fault | output | 1 | Alignment fault or memory error |
| resp_line_x | output | 1 | Access spans two cache lines |
| resp_page_x | output | 1 | Access spans two pages |
| resp_rdata | output | 128 | Merged load result |

## Verification
The bench targets these corner cases:
- Accesses that end exactly on lane 7. A mask computed one lane off would add a spurious second piece, or leave the top byte unwritten.
- A 16-byte access misaligned inside a beat, which needs three pieces. A unit that assumes at most two pieces would drop the tail bytes of the result.
- The page-offset-4088 case, and a beat crossing that stays inside one line. A wrong line or page comparison would raise or miss a flag.
- An alignment fault, which must leave the memory untouched, and a memory error on the first piece, which must suppress the second.
- A request arriving while busy. A unit that accepted it would show an extra transaction at an unrelated address.

// File: rtl/mis_split_unit.sv
module mis_split_unit #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_size,
  input  logic          req_write,
  input  logic          req_align,
  input  logic [127:0]  req_wdata,
  output logic          busy,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_write,
  output logic [7:0]    mem_mask,
  output logic [63:0]   mem_wdata,
  output logic [1:0]    mem_tag,
  input  logic          mem_rvalid,
  input  logic [63:0]   mem_rdata,
  input  logic          mem_rerr,
  output logic          resp_valid,
  output logic          resp_fault,
  output logic          resp_line_x,
  output logic          resp_page_x,
  output logic [127:0]  resp_rdata
);
  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int PAGE_SH = $clog2(PAGE_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} st_t;
  st_t st;

  logic [AW-1:0]  a_addr;
  logic [4:0]     a_n;
  logic           a_wr, fault, line_x, page_x;
  logic [1:0]     a_last, beat;
  logic [23:0]    lanes;
  logic [191:0]   wbuf, rbuf;

  logic [4:0]     n_req, span_req;
  logic [AW-1:0]  last_req;
  logic           mis_req, take;

  assign n_req    = (req_size >= 3'd4) ? 5'd16 : (5'd1 << req_size);
  assign span_req = {2'b00, req_addr[2:0]} + n_req - 5'd1;
  assign last_req = req_addr + AW'(n_req) - AW'(1);
  assign mis_req  = (req_addr[3:0] & (n_req[3:0] - 4'd1)) != 4'd0;
  assign take     = (st == S_IDLE) && req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  a_addr <= '0; a_n <= '0; a_wr <= 1'b0; fault <= 1'b0;
      line_x <= 1'b0; page_x <= 1'b0; a_last <= '0; beat <= '0;
      lanes <= '0; wbuf <= '0; rbuf <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          a_addr <= req_addr;
          a_n    <= n_req;
          a_wr   <= req_write;
          a_last <= 2'(span_req >> 3);
          lanes  <= ((24'd1 << n_req) - 24'd1) << req_addr[2:0];
          wbuf   <= {64'd0, req_wdata} << {req_addr[2:0], 3'b000};
          rbuf   <= '0;
          beat   <= '0;
          line_x <= (req_addr >> LINE_SH) != (last_req >> LINE_SH);
          page_x <= (req_addr >> PAGE_SH) != (last_req >> PAGE_SH);
          fault  <= req_align && mis_req;
          st     <= (req_align && mis_req) ? S_RESP : S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          rbuf[{beat, 6'b000000} +: 64] <= mem_rdata;
          if (mem_rerr) begin
            fault <= 1'b1;
            st    <= S_RESP;
          end else if (beat == a_last) begin
            st <= S_RESP;
          end else begin
            beat <= beat + 2'd1;
            st   <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign mem_valid = (st == S_ISSUE);
  assign mem_addr  = {a_addr[AW-1:3], 3'b000} + AW'({beat, 3'b000});
  assign mem_write = a_wr;
  assign mem_mask  = lanes[{beat, 3'b000} +: 8];
  assign mem_wdata = wbuf[{beat, 6'b000000} +: 64];
  assign mem_tag   = beat;

  logic [127:0] rsh, keep;
  logic [15:0]  kb;
  assign rsh = 128'(rbuf >> {a_addr[2:0], 3'b000});
  assign kb  = a_n[4] ? 16'hFFFF : ((16'd1 << a_n) - 16'd1);
  for (genvar i = 0; i < 16; i++) begin : g_keep
    assign keep[i*8 +: 8] = {8{kb[i]}};
  end

  assign resp_valid  = (st == S_RESP);
  assign resp_fault  = resp_valid && fault;
  assign resp_line_x = line_x;
  assign resp_page_x = page_x;
  assign resp_rdata  = (resp_valid && !fault && !a_wr) ? (rsh & keep) : '0;

  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_align && mis_req |=> resp_valid && resp_fault && !mem_valid); // R7
  AST_ABORT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) && mem_rvalid && mem_rerr |=> resp_fault && !mem_valid); // R11
  AST_SINGLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && (a_last == 2'd0) |-> $countones(mem_mask) == int'(a_n)); // R2
  AST_FIRST_TO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && (mem_tag == 2'd0) && (a_last != 2'd0) |-> mem_mask[7]); // R3
  AST_LATER_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && (mem_tag != 2'd0) |-> mem_mask[0]); // R3
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid |=> $stable(a_addr)); // R6
  AST_ALIGNED16_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    take && (n_req == 5'd16) && (req_addr[3:0] == 4'd0) |=> !resp_line_x); // R12
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R5
endmodule

// File: tb/mis_split_unit_tb.sv
module mis_split_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_align = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0] req_size = '0;
  logic [127:0] req_wdata = '0;
  logic busy, mem_valid, mem_write, resp_valid, resp_fault, resp_line_x, resp_page_x;
  logic [31:0] mem_addr;
  logic [7:0] mem_mask;
  logic [63:0] mem_wdata;
  logic [1:0] mem_tag;
  logic mem_rvalid = 1'b0, mem_rerr = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic [127:0] resp_rdata;

  int nchk = 0, nerr = 0, nlog = 0, err_tag = -1;
  logic [31:0] la [0:63];
  logic [7:0]  lm [0:63];
  logic [63:0] ld [0:63];
  logic [1:0]  lt [0:63];

  always #2 clk = ~clk;

  mis_split_unit dut_i (.*);

  function automatic logic [7:0] pat(input logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    mem_rerr   <= 1'b0;
    if (mem_valid) begin
      logic [63:0] d;
      for (int l = 0; l < 8; l++) d[l*8 +: 8] = pat(mem_addr + 32'(l));
      la[nlog % 64] <= mem_addr; lm[nlog % 64] <= mem_mask;
      ld[nlog % 64] <= mem_wdata; lt[nlog % 64] <= mem_tag;
      nlog <= nlog + 1;
      mem_rvalid <= 1'b1;
      mem_rdata  <= d;
      mem_rerr   <= (int'(mem_tag) == err_tag);
    end
  end

  task automatic chk(input bit ok, input string r, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] a, input int sz, input bit wr, input bit al,
                     input logic [127:0] wd, input int etag);
    int n = (sz >= 4) ? 16 : (1 << sz);
    int start, lat = 0, nb, expb;
    bit mis, xfault, rf, lx, px;
    logic [127:0] er = '0, rd;
    string rt;
    err_tag = etag;
    @(negedge clk);
    start = nlog;
    req_valid = 1'b1; req_addr = a; req_size = 3'(sz); req_write = wr;
    req_align = al; req_wdata = wd;
    do begin
      @(negedge clk);
      if (lat == 0) req_valid = 1'b0;
      lat++;
    end while (!resp_valid && lat < 100);
    rf = resp_fault; lx = resp_line_x; px = resp_page_x; rd = resp_rdata;
    mis  = al && ((a % n) != 0);
    nb   = ((a % 8) + n + 7) / 8;
    expb = mis ? 0 : ((etag >= 0) ? etag + 1 : nb);
    xfault = mis || (etag >= 0);
    rt = (nb > 1) ? "R3" : "R2";
    chk(resp_valid, "R5 response seen", 128'(resp_valid), 1);
    chk(nlog - start == expb, mis ? "R7 piece count" : (etag >= 0 ? "R11 piece count" : rt),
        128'(nlog - start), 128'(expb));
    chk(lat == (mis ? 1 : 2 * expb + 1), "R5 response cycle", 128'(lat), 128'(mis ? 1 : 2 * expb + 1));
    chk(rf == xfault, mis ? "R7 fault" : "R11 fault", 128'(rf), 128'(xfault));
    for (int k = 0; k < expb && k < nlog - start; k++) begin
      logic [31:0] base = (a & ~32'd7) + 32'(8 * k);
      logic [7:0] em = '0;
      for (int l = 0; l < 8; l++) begin
        if (base + 32'(l) >= a && base + 32'(l) < a + 32'(n)) begin
          em[l] = 1'b1;
          if (wr) chk(ld[(start + k) % 64][l*8 +: 8] == wd[(base + 32'(l) - a) * 8 +: 8],
                      "R4 lane data", 128'(ld[(start + k) % 64][l*8 +: 8]),
                      128'(wd[(base + 32'(l) - a) * 8 +: 8]));
        end
      end
      chk(la[(start + k) % 64] == base, {rt, " address"}, 128'(la[(start + k) % 64]), 128'(base));
      chk(lm[(start + k) % 64] == em, {rt, " mask"}, 128'(lm[(start + k) % 64]), 128'(em));
      chk(int'(lt[(start + k) % 64]) == k, {rt, " tag"}, 128'(lt[(start + k) % 64]), 128'(k));
    end
    if (!wr && !xfault) for (int i = 0; i < n; i++) er[i*8 +: 8] = pat(a + 32'(i));
    chk(rd == er, "R5 read data", rd, er);
    chk(lx == ((a / 64) != ((a + 32'(n) - 1) / 64)), "R9 line flag", 128'(lx),
        128'((a / 64) != ((a + 32'(n) - 1) / 64)));
    chk(px == ((a / 4096) != ((a + 32'(n) - 1) / 4096)), "R10 page flag", 128'(px),
        128'((a / 4096) != ((a + 32'(n) - 1) / 4096)));
    @(negedge clk);
    chk(!resp_valid && !busy, "R5 one-cycle response", 128'(resp_valid), 0);
    err_tag = -1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !mem_valid && !resp_valid, "R1 reset state", {busy, mem_valid, resp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_valid && !resp_valid, "R1 after reset", {busy, mem_valid, resp_valid}, 0);
  endtask

  task automatic t_single();
    run(32'h103, 1, 1'b0, 1'b0, '0, -1);              // R2 two bytes in beat
    run(32'h207, 0, 1'b1, 1'b0, 128'hAB, -1);         // R2 R4 top lane byte
    run(32'h300, 3, 1'b0, 1'b0, '0, -1);              // R2 full beat
  endtask

  task automatic t_split();
    run(32'h105, 3, 1'b0, 1'b0, '0, -1);              // R3 R5
    run(32'h1FE, 2, 1'b1, 1'b0, 128'h44332211, -1);   // R3 R4
    run(32'h304, 4, 1'b0, 1'b0, '0, -1);              // R3 three pieces
    run(32'h30B, 4, 1'b1, 1'b0, 128'h0F0E0D0C0B0A09080706050403020100, -1);
  endtask

  task automatic t_align();
    run(32'h102, 2, 1'b0, 1'b1, '0, -1);              // R7 fault, no access
    run(32'h10C, 3, 1'b1, 1'b1, 128'h1, -1);          // R7 fault on store
    run(32'h108, 3, 1'b0, 1'b1, '0, -1);              // R8 aligned with flag
    run(32'h10E, 2, 1'b0, 1'b0, '0, -1);              // R8 misaligned, flag clear
  endtask

  task automatic t_bounds();
    run(32'h13C, 3, 1'b0, 1'b0, '0, -1);              // R9 line crossing
    run(32'h1FF8, 4, 1'b0, 1'b0, '0, -1);             // R10 page offset 4088
    run(32'h2FFF, 1, 1'b1, 1'b0, 128'hBEEF, -1);      // R10 byte-level page cross
    run(32'h330, 4, 1'b0, 1'b1, '0, -1);              // R12 aligned 16B
    run(32'h3F0, 4, 1'b0, 1'b0, '0, -1);              // R12 aligned 16B at line end
  endtask

  task automatic t_error();
    run(32'h105, 3, 1'b0, 1'b0, '0, 0);               // R11 error on first piece
    run(32'h304, 4, 1'b1, 1'b0, 128'h5, 1);           // R11 error on middle piece
  endtask

  task automatic t_busy();
    int start, lat = 0;
    @(negedge clk);
    start = nlog;
    req_valid = 1'b1; req_addr = 32'h105; req_size = 3'd3; req_write = 1'b0; req_align = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R6 busy after accept", 128'(busy), 1);
    req_valid = 1'b1; req_addr = 32'h400; req_size = 3'd0; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid && lat < 100) begin @(negedge clk); lat++; end
    chk(busy, "R6 busy in response cycle", 128'(busy), 1);
    repeat (6) @(negedge clk);
    chk(nlog - start == 2, "R6 ignored request count", 128'(nlog - start), 2);
    chk(la[(start + 1) % 64] == 32'h108, "R6 ignored request address",
        128'(la[(start + 1) % 64]), 128'h108);
    chk(!busy, "R6 idle afterwards", 128'(busy), 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_split();
    t_align();
    t_bounds();
    t_error();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule